// File: doc/BRIEF.md
# Atomic Halfword Swap Execution Unit

This unit takes one 32-bit instruction word from the halfword-swap family and runs the whole operation. It checks the encoding and picks out three register indices. It forms an address from either a general register or the stack pointer. It then performs a locked read-then-write of one 16-bit halfword at that address. The old halfword comes back, zero-extended to 32 bits, on a register write-back port.

Two encoding bits select one of four ordering variants: plain, acquire, release, and acquire-release. The unit does not enforce ordering. It reports the qualifiers as flags for as long as the operation is in flight, together with a flag saying whether the access is tag-checked.

Encodings that do not belong to the family are rejected with a fault, and so are unusable addresses. A faulting instruction touches neither memory nor the register file. Only one instruction is in flight at a time.

Top module: `hswap_unit`

## Requirements
- R1: An instruction word is legal only when bits 31:24 equal 8'b01111000, bit 21 is 1 and bits 15:10 equal 6'b100000. An accepted illegal word raises `fault_undef` for exactly the cycle after acceptance and causes no memory request and no write-back.
- R2: `rf_src_idx` shows `instr_word[20:16]` and `rf_base_idx` shows `instr_word[9:5]` combinationally. The write-back index is `instr_word[4:0]` of the accepted word.
- R3: Bit 23 is the acquire qualifier and bit 22 is the release qualifier. While an operation is in flight (first read-request cycle through the write-back cycle), `flag_acq` equals acquire AND (destination index != 31), and `flag_rel` equals release. Both are 0 when no operation is in flight.
- R4: While an operation is in flight, `flag_tag` is 1 exactly when the base index is not 31. It is 0 when no operation is in flight.
- R5: The access address is `sp_value` when the base index is 31, and otherwise the 64-bit `rf_base_data` captured at acceptance.
- R6: When the base index is 31 and any of `sp_value[3:0]` is nonzero, `fault_sp_align` is raised for the cycle after acceptance, with no memory request and no write-back. An illegal encoding takes priority over this fault.
- R7: When the address has bit 0 set (and no R1 or R6 fault applies), `fault_misalign` is raised for the cycle after acceptance, with no memory request and no write-back.
- R8: A legal operation first holds a read (`mem_req`=1, `mem_we`=0) until `mem_ack`. It then holds a write (`mem_req`=1, `mem_we`=1) of `rf_src_data` captured at acceptance, at the same address, until `mem_ack`. `mem_lock` is 1 in every one of these cycles, and there is no idle gap between the read and the write.
- R9: In the cycle after the write acknowledge, the unit presents the read halfword zero-extended to 32 bits on `wb_data`, and `wb_en` is high for that single cycle.
- R10: When the destination index is 31, `wb_en` stays low, but the read and write to memory still take place.
- R11: `instr_ready` is 1 exactly when no operation is in flight. After reset the unit is idle, with no memory request, no flags, no faults and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle and able to accept |
| instr_word | input | 32 | Instruction word |
| rf_src_idx | output | 5 | Register read index for the store-source register |
| rf_src_data | input | 16 | Low halfword of the store-source register |
| rf_base_idx | output | 5 | Register read index for the base register |
| rf_base_data | input | 64 | Base register value |
| sp_value | input | 64 | Current stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Holds the read and write as one indivisible pair |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 16 | Halfword to store |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 16 | Read halfword, valid with `mem_ack` on a read |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Zero-extended old halfword |
| flag_acq | output | 1 | Acquire semantics in effect |
| flag_rel | output | 1 | Release semantics in effect |
| flag_tag | output | 1 | Access is tag-checked |
| fault_undef | output | 1 | Illegal encoding fault |
| fault_sp_align | output | 1 | Stack-pointer alignment fault |
| fault_misalign | output | 1 | Halfword misalignment fault |

## Verification
A wrong sequencer state shows at the ports in the first cycle after the edge where it goes wrong. Possible symptoms are a request appearing or vanishing, `mem_we` flipping early, `mem_lock` dropping between the read and the write, or `instr_ready` rising while an operation is still open. A corrupted captured operand shows up later. A bad address or store value appears on the next request cycle. A bad flag appears throughout the in-flight window. A wrong read capture appears only in the write-back cycle and in the halfword that a following swap of the same address returns. A mis-prioritised fault shows on the fault outputs in the cycle after acceptance, and also as an unexpected memory request.

// File: rtl/hswap_pkg.sv
package hswap_pkg;

    localparam int INSTR_W      = 32;
    localparam int IDX_W        = 5;
    localparam int ADDR_W       = 64;
    localparam int HALF_W       = 16;
    localparam int WB_W         = 32;
    localparam int SP_ALIGN_LSB = 4;

    localparam logic [IDX_W-1:0] ZERO_IDX = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WB
    } hs_state_e;

    typedef enum logic [1:0] {
        FLT_NONE,
        FLT_UNDEF,
        FLT_SP,
        FLT_MIS
    } hs_fault_e;

    typedef struct packed {
        logic              acq;
        logic              rel;
        logic              tag;
        logic [IDX_W-1:0]  dst;
        logic [ADDR_W-1:0] addr;
        logic [HALF_W-1:0] wdata;
    } hs_op_t;

    function automatic logic enc_legal(input logic [INSTR_W-1:0] w);
        return (w[31:24] == 8'b0111_1000) && w[21] && (w[15:10] == 6'b10_0000);
    endfunction

    function automatic logic [WB_W-1:0] zext_half(input logic [HALF_W-1:0] h);
        return {{(WB_W-HALF_W){1'b0}}, h};
    endfunction

endpackage

// File: rtl/hswap_decode.sv
module hswap_decode
    import hswap_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  base_data,
    input  logic [HALF_W-1:0]  src_data,
    input  logic [ADDR_W-1:0]  sp,
    output logic [IDX_W-1:0]   src_idx,
    output logic [IDX_W-1:0]   base_idx,
    output hs_op_t             op,
    output hs_fault_e          fault
);

    logic [IDX_W-1:0] dst_idx;
    logic             base_is_sp;
    logic             sp_bad;

    assign src_idx    = instr[20:16];
    assign base_idx   = instr[9:5];
    assign dst_idx    = instr[4:0];
    assign base_is_sp = (base_idx == ZERO_IDX);
    assign sp_bad     = |sp[SP_ALIGN_LSB-1:0];

    always_comb begin
        op.acq   = instr[23] && (dst_idx != ZERO_IDX);
        op.rel   = instr[22];
        op.tag   = !base_is_sp;
        op.dst   = dst_idx;
        op.addr  = base_is_sp ? sp : base_data;
        op.wdata = src_data;
    end

    // Priority: encoding, then stack-pointer alignment, then halfword alignment
    always_comb begin
        if (!enc_legal(instr))
            fault = FLT_UNDEF;
        else if (base_is_sp && sp_bad)
            fault = FLT_SP;
        else if (op.addr[0])
            fault = FLT_MIS;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/hswap_seq.sv
module hswap_seq
    import hswap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  hs_op_t            op_in,
    input  hs_fault_e         fault_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [HALF_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [HALF_W-1:0] mem_rdata,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [WB_W-1:0]   wb_data,
    output logic              flag_acq,
    output logic              flag_rel,
    output logic              flag_tag,
    output logic              fault_undef,
    output logic              fault_sp_align,
    output logic              fault_misalign
);

    hs_state_e         state;
    hs_op_t            op_q;
    logic [HALF_W-1:0] old_q;
    hs_fault_e         fault_q;
    logic              busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= '0;
            old_q   <= '0;
            fault_q <= FLT_NONE;
        end else begin
            fault_q <= FLT_NONE;
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        if (fault_in != FLT_NONE) begin
                            fault_q <= fault_in;
                        end else begin
                            op_q  <= op_in;
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        old_q <= mem_rdata;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack)
                        state <= ST_WB;
                end
                ST_WB: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign in_ready  = !busy;

    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_lock  = mem_req;
    assign mem_addr  = op_q.addr;
    assign mem_wdata = op_q.wdata;

    assign wb_en     = (state == ST_WB) && (op_q.dst != ZERO_IDX);
    assign wb_idx    = op_q.dst;
    assign wb_data   = zext_half(old_q);

    assign flag_acq  = busy && op_q.acq;
    assign flag_rel  = busy && op_q.rel;
    assign flag_tag  = busy && op_q.tag;

    assign fault_undef    = (fault_q == FLT_UNDEF);
    assign fault_sp_align = (fault_q == FLT_SP);
    assign fault_misalign = (fault_q == FLT_MIS);

endmodule

// File: rtl/hswap_unit.sv
module hswap_unit
    import hswap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    output logic               instr_ready,
    input  logic [INSTR_W-1:0] instr_word,
    output logic [IDX_W-1:0]   rf_src_idx,
    input  logic [HALF_W-1:0]  rf_src_data,
    output logic [IDX_W-1:0]   rf_base_idx,
    input  logic [ADDR_W-1:0]  rf_base_data,
    input  logic [ADDR_W-1:0]  sp_value,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_lock,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [HALF_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [HALF_W-1:0]  mem_rdata,
    output logic               wb_en,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [WB_W-1:0]    wb_data,
    output logic               flag_acq,
    output logic               flag_rel,
    output logic               flag_tag,
    output logic               fault_undef,
    output logic               fault_sp_align,
    output logic               fault_misalign
);

    hs_op_t    dec_op;
    hs_fault_e dec_fault;

    hswap_decode u_decode (
        .instr     (instr_word),
        .base_data (rf_base_data),
        .src_data  (rf_src_data),
        .sp        (sp_value),
        .src_idx   (rf_src_idx),
        .base_idx  (rf_base_idx),
        .op        (dec_op),
        .fault     (dec_fault)
    );

    hswap_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (instr_valid),
        .in_ready       (instr_ready),
        .op_in          (dec_op),
        .fault_in       (dec_fault),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_lock       (mem_lock),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .wb_en          (wb_en),
        .wb_idx         (wb_idx),
        .wb_data        (wb_data),
        .flag_acq       (flag_acq),
        .flag_rel       (flag_rel),
        .flag_tag       (flag_tag),
        .fault_undef    (fault_undef),
        .fault_sp_align (fault_sp_align),
        .fault_misalign (fault_misalign)
    );

endmodule

// File: rtl/hswap_unit_chk.sv
module hswap_unit_chk
    import hswap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               instr_ready,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_lock,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_ack,
    input logic               wb_en,
    input logic [IDX_W-1:0]   wb_idx,
    input logic [WB_W-1:0]    wb_data,
    input logic               flag_acq,
    input logic               flag_rel,
    input logic               fault_undef,
    input logic               fault_sp_align,
    input logic               fault_misalign
);

    assert_lock_covers_req_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);

    assert_addr_held_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    assert_write_follows_read_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !$past(mem_we)) |-> $past(mem_req && !mem_we && mem_ack));

    assert_read_ack_opens_write_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    assert_faults_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_undef, fault_sp_align, fault_misalign}));

    assert_fault_no_access_R6: assert property (@(posedge clk) disable iff (rst)
        (fault_undef || fault_sp_align || fault_misalign) |-> !mem_req && !wb_en);

    assert_wb_zero_ext_R9: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_data[WB_W-1:HALF_W] == '0));

    assert_wb_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(mem_req && mem_we && mem_ack));

    assert_wb_not_zero_reg_R10: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx != ZERO_IDX));

    assert_ready_only_idle_R11: assert property (@(posedge clk) disable iff (rst)
        instr_ready |-> !mem_req && !wb_en && !flag_acq && !flag_rel);

endmodule

bind hswap_unit hswap_unit_chk u_chk (.*);

// File: tb/tb_hswap_unit.sv
`timescale 1ns/1ps
module tb_hswap_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [31:0] instr_word = '0;
    logic [4:0]  rf_src_idx, rf_base_idx;
    logic [15:0] rf_src_data;
    logic [63:0] rf_base_data;
    logic [63:0] sp_value = '0;
    logic        mem_req, mem_we, mem_lock;
    logic [63:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        flag_acq, flag_rel, flag_tag;
    logic        fault_undef, fault_sp_align, fault_misalign;

    always #2.5 clk = ~clk;

    logic [63:0] gpr [0:31];
    logic [15:0] mem [0:255];

    assign rf_base_data = gpr[rf_base_idx];
    assign rf_src_data  = gpr[rf_src_idx][15:0];

    hswap_unit dut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int lat      = 0;
    int cnt      = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory responder: acknowledges after 'lat' wait cycles
    always @(posedge clk) begin
        #1;
        if (rst) begin
            mem_ack = 0; cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 0; cnt = 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_ack   = 1;
                mem_rdata = mem[mem_addr[8:1]];
            end else begin
                cnt++;
            end
        end
    end

    always @(posedge clk)
        if (!rst && mem_req && mem_we && mem_ack)
            mem[mem_addr[8:1]] = mem_wdata;

    // Behavioural reference model
    int          ph = 0;
    int          m_flt = 0;
    logic [63:0] m_addr = '0;
    logic [15:0] m_wd = '0, m_old = '0;
    logic [4:0]  m_dst = '0;
    bit          m_acq = 0, m_rel = 0, m_tag = 0;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; m_flt = 0;
        end else begin
            m_flt = 0;
            case (ph)
                0: if (instr_valid) begin
                    logic [4:0]  b, s, t;
                    logic [63:0] a;
                    bit legal;
                    b = instr_word[9:5]; s = instr_word[20:16]; t = instr_word[4:0];
                    a = (b == 31) ? sp_value : gpr[b];
                    legal = instr_word[31:24] == 8'h78 && instr_word[21] && instr_word[15:10] == 6'b100000;
                    if (!legal) m_flt = 1;
                    else if (b == 31 && sp_value[3:0] != 0) m_flt = 2;
                    else if (a[0]) m_flt = 3;
                    else begin
                        ph = 1; m_addr = a; m_wd = gpr[s][15:0]; m_dst = t;
                        m_acq = instr_word[23] && t != 31;
                        m_rel = instr_word[22];
                        m_tag = b != 31;
                    end
                end
                1: if (mem_ack) begin m_old = mem_rdata; ph = 2; end
                2: if (mem_ack) ph = 3;
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit busy;
            busy = ph != 0;
            check(instr_ready == (ph == 0), "R11 ready", instr_ready, ph == 0);
            check(mem_req == (ph == 1 || ph == 2), "R8 req", mem_req, ph == 1 || ph == 2);
            check(mem_we == (ph == 2), "R8 we", mem_we, ph == 2);
            check(mem_lock == (ph == 1 || ph == 2), "R8 lock", mem_lock, ph == 1 || ph == 2);
            if (busy && ph != 3) check(mem_addr == m_addr, "R5 addr", mem_addr, m_addr);
            if (ph == 2) check(mem_wdata == m_wd, "R8 wdata", mem_wdata, m_wd);
            check(wb_en == (ph == 3 && m_dst != 31), "R9/R10 wb_en", wb_en, ph == 3 && m_dst != 31);
            if (ph == 3) begin
                check(wb_data == {16'h0, m_old}, "R9 wb_data", wb_data, {16'h0, m_old});
                check(wb_idx == m_dst, "R2 wb_idx", wb_idx, m_dst);
            end
            check(flag_acq == (busy && m_acq), "R3 acq", flag_acq, busy && m_acq);
            check(flag_rel == (busy && m_rel), "R3 rel", flag_rel, busy && m_rel);
            check(flag_tag == (busy && m_tag), "R4 tag", flag_tag, busy && m_tag);
            check(fault_undef == (m_flt == 1), "R1 undef", fault_undef, m_flt == 1);
            check(fault_sp_align == (m_flt == 2), "R6 sp", fault_sp_align, m_flt == 2);
            check(fault_misalign == (m_flt == 3), "R7 mis", fault_misalign, m_flt == 3);
            check(rf_src_idx == instr_word[20:16], "R2 src_idx", rf_src_idx, instr_word[20:16]);
            check(rf_base_idx == instr_word[9:5], "R2 base_idx", rf_base_idx, instr_word[9:5]);
        end
    end

    function automatic logic [31:0] enc(bit a, bit r, logic [4:0] s, logic [4:0] n, logic [4:0] t);
        return {8'b0111_1000, a, r, 1'b1, s, 6'b10_0000, n, t};
    endfunction

    task automatic issue(input logic [31:0] w);
        @(posedge clk); #1;
        while (!instr_ready) begin @(posedge clk); #1; end
        instr_word  = w;
        instr_valid = 1;
        @(posedge clk); #1;
        instr_valid = 0;
        while (!instr_ready) begin @(posedge clk); #1; end
        repeat (2) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) gpr[i] = 64'h0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101 + 16'h5a);
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        @(negedge clk);
        check(instr_ready && !mem_req && !wb_en && !fault_undef, "R11 reset state",
              {instr_ready, mem_req, wb_en, fault_undef}, 4'b1000);

        // plain swap
        gpr[3] = 64'h10; gpr[4] = 64'hFFFF_0000_0000_BEEF; mem[8] = 16'h1234;
        issue(enc(0, 0, 5'd4, 5'd3, 5'd5));
        check(mem[8] == 16'hBEEF, "R8 memory updated", mem[8], 16'hBEEF);

        // acquire-release with slow memory
        lat = 2; gpr[6] = 64'h2A; gpr[7] = 64'h8001; mem[21] = 16'hF00D;
        issue(enc(1, 1, 5'd7, 5'd6, 5'd8));
        check(mem[21] == 16'h8001, "R8 slow memory updated", mem[21], 16'h8001);

        // acquire with zero destination: no write-back, swap still done
        lat = 1; gpr[9] = 64'h60; gpr[10] = 64'h7777; mem[48] = 16'h0ABC;
        issue(enc(1, 0, 5'd10, 5'd9, 5'd31));
        check(mem[48] == 16'h7777, "R10 swap with zero destination", mem[48], 16'h7777);

        // release via aligned stack pointer
        lat = 0; sp_value = 64'h40; gpr[11] = 64'h4242; mem[32] = 16'hCAFE;
        issue(enc(0, 1, 5'd11, 5'd31, 5'd12));
        check(mem[32] == 16'h4242, "R5 stack pointer address", mem[32], 16'h4242);

        // misaligned stack pointer
        sp_value = 64'h48; mem[36] = 16'h1111;
        issue(enc(0, 0, 5'd11, 5'd31, 5'd12));
        check(mem[36] == 16'h1111, "R6 no access on sp fault", mem[36], 16'h1111);

        // odd address
        gpr[13] = 64'h21; mem[16] = 16'h2222;
        issue(enc(0, 0, 5'd11, 5'd13, 5'd12));
        check(mem[16] == 16'h2222, "R7 no access on misalign", mem[16], 16'h2222);

        // illegal encodings, one with a misaligned stack pointer too
        issue(enc(0, 0, 5'd4, 5'd3, 5'd5) & ~32'h0020_0000);
        issue(enc(0, 0, 5'd4, 5'd3, 5'd5) ^ 32'h0000_0400);
        issue(enc(0, 0, 5'd4, 5'd31, 5'd5) ^ 32'h4000_0000);
        check(mem[8] == 16'hBEEF, "R1 no access on illegal", mem[8], 16'hBEEF);

        // back-to-back swaps of one address return the previous store
        gpr[14] = 64'h80; gpr[15] = 64'h1357; gpr[16] = 64'h2468;
        issue(enc(0, 0, 5'd15, 5'd14, 5'd17));
        lat = 3;
        issue(enc(1, 1, 5'd16, 5'd14, 5'd18));
        check(mem[64] == 16'h2468, "R9 chained swap", mem[64], 16'h2468);

        repeat (4) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule